// File: doc/BRIEF.md
# Serial Ones-Count Modulo-3 Detector

This block watches a one-bit serial stream and keeps the number of ones it has received, reduced modulo three. A bit is taken only in a clock cycle where the sample strobe is high. A registered flag is high whenever the count of ones taken so far is a multiple of three. Zero ones counts as a multiple of three, so the flag is high straight after reset.

The remainder itself appears on a two-bit output next to the flag. A checker or a software reference can compare against it cycle by cycle. The machine is of the Moore type: the flag depends only on the stored remainder, never directly on the current input bit. Its state always has one of three legal codes. If the register ever holds the spare fourth code, the machine returns to the remainder-zero state on the next sampled cycle.

Top module: `ones_mod3_detector`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state loads remainder 0, so `rem_state` reads 2'b00 and `div_by3` reads 1 after that edge.
- R2: On an edge where `sample_en` is 1 and `bit_in` is 1, the remainder advances in the cycle 0 to 1, 1 to 2, and 2 back to 0.
- R3: On an edge where `sample_en` is 1 and `bit_in` is 0, a legal remainder is kept unchanged.
- R4: On an edge where `sample_en` is 0, `rem_state` and `div_by3` stay unchanged, whatever the value of `bit_in`.
- R5: `div_by3` is 1 exactly when `rem_state` holds remainder 0, and it is 0 for remainders 1 and 2. Both outputs come from registers and change on the same edge.
- R6: `rem_state` encodes the remainder as 2'b00 for 0, 2'b01 for 1 and 2'b10 for 2.
- R7: If the state register holds the spare code 2'b11, the next edge with `sample_en` high loads 2'b00 and sets `div_by3`, whatever the value of `bit_in`.
- R8: Reset takes priority over sampling: an edge with `rst`, `sample_en` and `bit_in` all high still leaves remainder 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_en | input | 1 | High in a cycle whose `bit_in` is to be taken |
| bit_in | input | 1 | Serial data bit |
| rem_state | output | 2 | Current remainder of the ones count modulo three |
| div_by3 | output | 1 | High when the ones count is a multiple of three |

## Verification
A fixed vector walk interleaves ones, zeros and idle strobes. Each remainder therefore meets all three input kinds, which separates the advance from the hold and from the idle hold, and includes the 2-to-0 wrap. A long pseudo-random stream with a sparse strobe is compared against a software running count. This exposes a miscounted ones bit, a zero taken as a one, or a bit taken while the strobe is low. Directed cases apply reset while a one is offered, to test priority, and inject the spare code into the state register, to confirm recovery regardless of the data bit.

// File: rtl/ones_mod3_pkg.sv
package ones_mod3_pkg;

  localparam int REM_W = 2;

  typedef enum logic [REM_W-1:0] {
    REM0    = 2'b00,
    REM1    = 2'b01,
    REM2    = 2'b10,
    REM_BAD = 2'b11
  } rem_t;

endpackage

// File: rtl/ones_mod3_next.sv
module ones_mod3_next
  import ones_mod3_pkg::*;
(
  input  rem_t cur_rem,
  input  logic take,
  input  logic one_bit,
  output rem_t nxt_rem
);

  always_comb begin
    nxt_rem = cur_rem;
    if (take) begin
      unique case (cur_rem)
        REM0:    nxt_rem = one_bit ? REM1 : REM0;
        REM1:    nxt_rem = one_bit ? REM2 : REM1;
        REM2:    nxt_rem = one_bit ? REM0 : REM2;
        default: nxt_rem = REM0;
      endcase
    end
  end

endmodule

// File: rtl/ones_mod3_state_reg.sv
module ones_mod3_state_reg
  import ones_mod3_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  rem_t d_rem,
  output rem_t state_q,
  output logic zero_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= REM0;
      zero_q  <= 1'b1;
    end else begin
      state_q <= d_rem;
      zero_q  <= (d_rem == REM0);
    end
  end

endmodule

// File: rtl/ones_mod3_detector.sv
module ones_mod3_detector
  import ones_mod3_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sample_en,
  input  logic             bit_in,
  output logic [REM_W-1:0] rem_state,
  output logic             div_by3
);

  rem_t cur_rem;
  rem_t nxt_rem;
  logic zero_q;

  ones_mod3_next u_next (
    .cur_rem (cur_rem),
    .take    (sample_en),
    .one_bit (bit_in),
    .nxt_rem (nxt_rem)
  );

  ones_mod3_state_reg u_state (
    .clk     (clk),
    .rst     (rst),
    .d_rem   (nxt_rem),
    .state_q (cur_rem),
    .zero_q  (zero_q)
  );

  assign rem_state = cur_rem;
  assign div_by3   = zero_q;

endmodule

// File: rtl/ones_mod3_checker.sv
module ones_mod3_checker (
  input logic       clk,
  input logic       rst,
  input logic       sample_en,
  input logic       bit_in,
  input logic [1:0] rem_state,
  input logic       div_by3
);

  AST_RESET_FLAG: assert property (@(posedge clk) rst |=> div_by3); // R1
  AST_ONE_FROM0: assert property (@(posedge clk) disable iff (rst)
    (!rst && sample_en && bit_in && rem_state == 2'b00) |=> rem_state == 2'b01); // R2
  AST_ONE_FROM1: assert property (@(posedge clk) disable iff (rst)
    (!rst && sample_en && bit_in && rem_state == 2'b01) |=> rem_state == 2'b10); // R2
  AST_ONE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!rst && sample_en && bit_in && rem_state == 2'b10) |=> (rem_state == 2'b00 && div_by3)); // R2
  AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!rst && sample_en && !bit_in && rem_state != 2'b11) |=> $stable(rem_state)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!rst && !sample_en) |=> ($stable(rem_state) && $stable(div_by3))); // R4
  AST_FLAG_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rem_state == 2'b00) |-> div_by3); // R5
  AST_FLAG_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (rem_state == 2'b01 || rem_state == 2'b10) |-> !div_by3); // R5
  AST_SPARE_RECOVER: assert property (@(posedge clk) disable iff (rst)
    (!rst && sample_en && rem_state == 2'b11) |=> (rem_state == 2'b00 && div_by3)); // R7
  AST_RESET_PRIORITY: assert property (@(posedge clk)
    (rst && sample_en && bit_in) |=> rem_state == 2'b00); // R8

endmodule

bind ones_mod3_detector ones_mod3_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .sample_en (sample_en),
  .bit_in    (bit_in),
  .rem_state (rem_state),
  .div_by3   (div_by3)
);

// File: tb/ones_mod3_detector_bench.sv
module ones_mod3_detector_bench;
  import ones_mod3_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sample_en = 1'b0;
  logic       bit_in = 1'b0;
  logic [1:0] rem_state;
  logic       div_by3;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int ref_rem = 0;
  logic [15:0] lfsr = 16'hACE1;

  // Each entry: {sample_en, bit_in, expected rem_state[1:0], expected div_by3}
  localparam int NVEC = 16;
  localparam logic [4:0] VEC [NVEC] = '{
    5'b11_01_0, 5'b10_01_0, 5'b11_10_0, 5'b01_10_0,
    5'b11_00_1, 5'b10_00_1, 5'b01_00_1, 5'b11_01_0,
    5'b11_10_0, 5'b11_00_1, 5'b00_00_1, 5'b11_01_0,
    5'b01_01_0, 5'b10_01_0, 5'b11_10_0, 5'b10_10_0
  };

  ones_mod3_detector u_ones_mod3_detector (
    .clk       (clk),
    .rst       (rst),
    .sample_en (sample_en),
    .bit_in    (bit_in),
    .rem_state (rem_state),
    .div_by3   (div_by3)
  );

  always #10 clk = ~clk;

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles, expected below 20000", cycles);
      finish_run();
    end
  end

  task automatic check_state(string req, logic [1:0] exp_s);
    checks = checks + 1;
    if (rem_state !== exp_s) begin
      errors = errors + 1;
      $display("FAIL %s rem_state: actual %b expected %b", req, rem_state, exp_s);
    end
  endtask

  task automatic check_flag(string req, logic exp_f);
    checks = checks + 1;
    if (div_by3 !== exp_f) begin
      errors = errors + 1;
      $display("FAIL %s div_by3: actual %b expected %b", req, div_by3, exp_f);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_state("R1", 2'b00);
    check_flag("R1", 1'b1);

    // Vector walk: R2 advance, R3 zero hold, R4 idle hold, R5 flag, R6 codes
    for (int i = 0; i < NVEC; i++) begin
      sample_en = VEC[i][4];
      bit_in    = VEC[i][3];
      @(negedge clk);
      if (!VEC[i][4]) check_state("R4 R6", VEC[i][2:1]);
      else if (VEC[i][3]) check_state("R2 R6", VEC[i][2:1]);
      else check_state("R3 R6", VEC[i][2:1]);
      check_flag("R5", VEC[i][0]);
    end
    ref_rem = 2;

    // Pseudo-random stream against a software running count
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sample_en = lfsr[0] & lfsr[3];
      bit_in    = lfsr[6];
      @(negedge clk);
      if (sample_en && bit_in) ref_rem = (ref_rem + 1) % 3;
      check_state("R2 R3 R4", 2'(ref_rem));
      check_flag("R5", ref_rem == 0);
    end

    // Make the remainder nonzero, then reset while a one is offered
    sample_en = 1'b1;
    bit_in = 1'b1;
    do begin
      @(negedge clk);
      ref_rem = (ref_rem + 1) % 3;
    end while (ref_rem == 0);
    check_state("R2", 2'(ref_rem));
    rst = 1'b1;
    @(negedge clk);
    check_state("R8", 2'b00);
    check_flag("R8", 1'b1);

    // One more reset cycle with the strobe low, then inject the spare code
    sample_en = 1'b0;
    bit_in = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    sample_en = 1'b0;
    force u_ones_mod3_detector.u_state.state_q = REM_BAD;
    #1;
    release u_ones_mod3_detector.u_state.state_q;
    sample_en = 1'b1;
    bit_in = 1'b1;
    @(negedge clk);
    check_state("R7", 2'b00);
    check_flag("R7", 1'b1);
    sample_en = 1'b0;
    @(negedge clk);
    check_state("R4", 2'b00);

    finish_run();
  end

endmodule